// File: doc/BRIEF.md
# In-Lane Single-Precision Permute Unit

This datapath block rearranges the 32-bit elements of a vector without ever moving data across a 128-bit lane. A 256-bit source holds two lanes of four elements each. Each result element is copied from one of the four elements in the same lane as that result position. Data moves bit for bit, with no floating-point interpretation, so no arithmetic exception can ever arise.

The element selects come from one of two places. In immediate mode, an 8-bit immediate supplies four 2-bit selects, and both lanes use the same four. In variable mode, a 256-bit control vector supplies one select per result element, taken from the two lowest bits of the matching control element.

A width bit chooses between the full 256-bit operation and a 128-bit form that clears the upper lane of the result. Two encoding fields are checked: a W bit and a 4-bit register specifier. An illegal combination raises an undefined-opcode flag and forces the result to zero. The result, the flag and a valid strobe are registered one cycle after the request.

Top module: `lane_permute_unit`

## Requirements
- R1: Result element i (bits 32i+31:32i) equals source element 4*(i/4)+s, where s is its 2-bit select. Select value s picks bits 32s+31:32s of that lane, so no data crosses the 128-bit lane boundary.
- R2: With var_mode_i=0 (immediate mode), result elements 0 to 3 take their selects from imm_i[1:0], [3:2], [5:4] and [7:6]. Elements 4 to 7 reuse the same four fields in that order.
- R3: With var_mode_i=1 (variable mode), the select for element i is ctl_i[32i+1:32i]. All other ctl_i bits have no effect on the result.
- R4: With wide_i=0, result_o[255:128] is zero and the lower lane follows R1 to R3. With wide_i=1, both lanes are produced.
- R5: In immediate mode, enc_vvvv_i other than 4'b1111 sets undef_o. In variable mode, enc_vvvv_i has no effect.
- R6: enc_w_i=1 sets undef_o in both modes.
- R7: When undef_o is set for a request, result_o is zero and valid_o is still asserted for that request.
- R8: valid_o is asserted in the cycle after the clock edge that samples valid_i=1 and is low otherwise. result_o and undef_o change only when a request is accepted.
- R9: Asserting rst_ni low clears valid_o, undef_o and result_o.
- R10: ctl_i has no effect in immediate mode, and imm_i has no effect in variable mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 256 | Source vector of eight 32-bit elements |
| imm_i | input | 8 | Four 2-bit selects used in immediate mode |
| ctl_i | input | 256 | Per-element control vector used in variable mode |
| var_mode_i | input | 1 | 0 selects immediate mode, 1 selects variable mode |
| wide_i | input | 1 | 1 selects the 256-bit form, 0 the 128-bit form |
| enc_w_i | input | 1 | Encoding W field; 1 is illegal |
| enc_vvvv_i | input | 4 | Encoding register specifier; must be 4'b1111 in immediate mode |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 256 | Permuted result |
| undef_o | output | 1 | Undefined-opcode flag for the request |

## Verification
The result register is the only state in the block. A wrong select, a lane mix-up or a bad mask therefore shows up in result_o one cycle after the faulty request, and it stays there until the next request. A decode fault shows up on undef_o in that same cycle, together with a result that is either zero when it should not be, or nonzero when it should be zero. Hold behaviour is checked on idle cycles, where any spurious load would corrupt the held value at once.

// File: rtl/perm_pkg.sv
package perm_pkg;
  parameter int unsigned ELEM_W_DEF     = 32;
  parameter int unsigned LANE_ELEMS_DEF = 4;
  parameter int unsigned LANES_DEF      = 2;
  parameter int unsigned VVVV_W         = 4;

  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_VAR = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/perm_sel_gen.sv
module perm_sel_gen #(
  parameter int unsigned ELEM_W     = 32,
  parameter int unsigned LANE_ELEMS = 4,
  parameter int unsigned LANES      = 2,
  localparam int unsigned SEL_W     = $clog2(LANE_ELEMS),
  localparam int unsigned NUM_ELEMS = LANE_ELEMS * LANES,
  localparam int unsigned VEC_W     = ELEM_W * NUM_ELEMS,
  localparam int unsigned IMM_W     = SEL_W * LANE_ELEMS
) (
  input  logic [IMM_W-1:0]           imm_i,
  input  logic [VEC_W-1:0]           ctl_i,
  input  perm_pkg::sel_mode_e        mode_i,
  output logic [NUM_ELEMS*SEL_W-1:0] sel_o
);
  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_sel
    // immediate fields repeat per lane; control uses low bits of each element
    localparam int unsigned IMM_POS = (e % LANE_ELEMS) * SEL_W;
    assign sel_o[e*SEL_W +: SEL_W] = (mode_i == perm_pkg::MODE_VAR)
                                   ? ctl_i[e*ELEM_W +: SEL_W]
                                   : imm_i[IMM_POS +: SEL_W];
  end
endmodule

// File: rtl/perm_lane_xbar.sv
module perm_lane_xbar #(
  parameter int unsigned ELEM_W     = 32,
  parameter int unsigned LANE_ELEMS = 4,
  localparam int unsigned SEL_W     = $clog2(LANE_ELEMS),
  localparam int unsigned LANE_W    = ELEM_W * LANE_ELEMS
) (
  input  logic [LANE_W-1:0]           lane_i,
  input  logic [LANE_ELEMS*SEL_W-1:0] sel_i,
  output logic [LANE_W-1:0]           lane_o
);
  for (genvar e = 0; e < LANE_ELEMS; e++) begin : g_elem
    logic [ELEM_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < LANE_ELEMS; k++) begin
        if (sel_i[e*SEL_W +: SEL_W] == SEL_W'(k)) pick = lane_i[k*ELEM_W +: ELEM_W];
      end
    end
    assign lane_o[e*ELEM_W +: ELEM_W] = pick;
  end
endmodule

// File: rtl/perm_decode.sv
module perm_decode (
  input  perm_pkg::sel_mode_e           mode_i,
  input  logic                          enc_w_i,
  input  logic [perm_pkg::VVVV_W-1:0]   enc_vvvv_i,
  output logic                          undef_o
);
  logic vvvv_bad;
  // specifier is reserved only when the immediate supplies the selects
  assign vvvv_bad = (mode_i == perm_pkg::MODE_IMM) && (enc_vvvv_i != '1);
  assign undef_o  = enc_w_i || vvvv_bad;
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int unsigned ELEM_W     = perm_pkg::ELEM_W_DEF,
  parameter int unsigned LANE_ELEMS = perm_pkg::LANE_ELEMS_DEF,
  parameter int unsigned LANES      = perm_pkg::LANES_DEF,
  localparam int unsigned SEL_W     = $clog2(LANE_ELEMS),
  localparam int unsigned NUM_ELEMS = LANE_ELEMS * LANES,
  localparam int unsigned LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int unsigned VEC_W     = LANE_W * LANES,
  localparam int unsigned IMM_W     = SEL_W * LANE_ELEMS,
  localparam int unsigned LSEL_W    = SEL_W * LANE_ELEMS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [VEC_W-1:0]            src_i,
  input  logic [IMM_W-1:0]            imm_i,
  input  logic [VEC_W-1:0]            ctl_i,
  input  logic                        var_mode_i,
  input  logic                        wide_i,
  input  logic                        enc_w_i,
  input  logic [perm_pkg::VVVV_W-1:0] enc_vvvv_i,
  output logic                        valid_o,
  output logic [VEC_W-1:0]            result_o,
  output logic                        undef_o
);
  perm_pkg::sel_mode_e mode;
  logic [NUM_ELEMS*SEL_W-1:0] sel;
  logic [VEC_W-1:0]           perm;
  logic [VEC_W-1:0]           next_res;
  logic                       undef;

  assign mode = perm_pkg::sel_mode_e'(var_mode_i);

  perm_sel_gen #(
    .ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS), .LANES(LANES)
  ) u_sel_gen (
    .imm_i (imm_i),
    .ctl_i (ctl_i),
    .mode_i(mode),
    .sel_o (sel)
  );

  perm_decode u_decode (
    .mode_i    (mode),
    .enc_w_i   (enc_w_i),
    .enc_vvvv_i(enc_vvvv_i),
    .undef_o   (undef)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    perm_lane_xbar #(
      .ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS)
    ) u_xbar (
      .lane_i(src_i[l*LANE_W +: LANE_W]),
      .sel_i (sel[l*LSEL_W +: LSEL_W]),
      .lane_o(lane_res)
    );
    if (l == 0) begin : g_low
      assign perm[l*LANE_W +: LANE_W] = lane_res;
    end else begin : g_high
      // narrow form keeps only the lowest lane
      assign perm[l*LANE_W +: LANE_W] = wide_i ? lane_res : '0;
    end
  end

  assign next_res = undef ? '0 : perm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      undef_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= next_res;
        undef_o  <= undef;
      end
    end
  end
endmodule

// File: rtl/perm_unit_checker.sv
module perm_unit_checker #(
  parameter int unsigned ELEM_W     = 32,
  parameter int unsigned LANE_ELEMS = 4,
  parameter int unsigned LANES      = 2,
  localparam int unsigned LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int unsigned VEC_W     = LANE_W * LANES,
  localparam int unsigned IMM_W     = $clog2(LANE_ELEMS) * LANE_ELEMS
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic [VEC_W-1:0]            src_i,
  input logic [IMM_W-1:0]            imm_i,
  input logic                        var_mode_i,
  input logic                        wide_i,
  input logic                        enc_w_i,
  input logic [perm_pkg::VVVV_W-1:0] enc_vvvv_i,
  input logic                        valid_o,
  input logic [VEC_W-1:0]            result_o,
  input logic                        undef_o
);
  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(undef_o)));
  assert_undef_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0));
  assert_w_undef_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_w_i) |=> undef_o);
  assert_vvvv_undef_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !var_mode_i && (enc_vvvv_i != '1)) |=> undef_o);
  assert_var_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && var_mode_i && !enc_w_i) |=> !undef_o);
  assert_narrow_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (result_o[VEC_W-1:LANE_W] == '0));
  // broadcast immediate of select 0 copies element 0 of the low lane
  assert_imm_bcast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !var_mode_i && !enc_w_i && (enc_vvvv_i == '1) && (imm_i == '0))
    |=> (result_o[ELEM_W-1:0] == $past(src_i[ELEM_W-1:0])));
endmodule

bind lane_permute_unit perm_unit_checker #(
  .ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS), .LANES(LANES)
) u_perm_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .src_i     (src_i),
  .imm_i     (imm_i),
  .var_mode_i(var_mode_i),
  .wide_i    (wide_i),
  .enc_w_i   (enc_w_i),
  .enc_vvvv_i(enc_vvvv_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .undef_o   (undef_o)
);

// File: tb/test_lane_permute_unit.sv
`timescale 1ns/1ps
module test_lane_permute_unit;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic [255:0] src_i;
  logic [7:0]   imm_i;
  logic [255:0] ctl_i;
  logic         var_mode_i;
  logic         wide_i;
  logic         enc_w_i;
  logic [3:0]   enc_vvvv_i;
  logic         valid_o;
  logic [255:0] result_o;
  logic         undef_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         exp_valid;
  logic [255:0] exp_res;
  logic         exp_undef;

  always #2.5 clk = ~clk;

  lane_permute_unit i_lane_permute_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .imm_i(imm_i), .ctl_i(ctl_i), .var_mode_i(var_mode_i), .wide_i(wide_i),
    .enc_w_i(enc_w_i), .enc_vvvv_i(enc_vvvv_i), .valid_o(valid_o),
    .result_o(result_o), .undef_o(undef_o)
  );

  function automatic logic [256:0] model(logic [255:0] s, logic [7:0] im,
      logic [255:0] c, logic vm, logic wd, logic w, logic [3:0] vv);
    logic [255:0] r = '0;
    logic u = w || (!vm && vv != 4'hf);
    for (int e = 0; e < 8; e++) begin
      int sel;
      int lane = e / 4;
      sel = vm ? int'(c[e*32 +: 2]) : int'(im[(e % 4)*2 +: 2]);
      if (wd || lane == 0) r[e*32 +: 32] = s[lane*128 + sel*32 +: 32];
    end
    if (u) r = '0;
    return {u, r};
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic compare(string tag);
    checks++;
    if (valid_o !== exp_valid || result_o !== exp_res || undef_o !== exp_undef) begin
      fails++;
      $display("FAIL %s: got v=%b u=%b r=%h exp v=%b u=%b r=%h", tag,
               valid_o, undef_o, result_o, exp_valid, exp_undef, exp_res);
    end
  endtask

  // called at negedge: drive, let edge pass, update model, compare at next negedge
  task automatic step(string tag, logic v, logic [255:0] s, logic [7:0] im,
      logic [255:0] c, logic vm, logic wd, logic w, logic [3:0] vv);
    logic [256:0] m;
    valid_i = v; src_i = s; imm_i = im; ctl_i = c;
    var_mode_i = vm; wide_i = wd; enc_w_i = w; enc_vvvv_i = vv;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      m = model(s, im, c, vm, wd, w, vv);
      exp_undef = m[256];
      exp_res = m[255:0];
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, rnd256(), 8'($urandom), rnd256(), 1'($urandom), 1'($urandom),
         1'($urandom), 4'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] s, c, c_low;
    rst_ni = 1'b0; valid_i = 0; src_i = '0; imm_i = '0; ctl_i = '0;
    var_mode_i = 0; wide_i = 0; enc_w_i = 0; enc_vvvv_i = 4'hf;
    exp_valid = 0; exp_res = '0; exp_undef = 0;
    repeat (3) @(negedge clk);
    compare("R9 reset state");
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) s[i*32 +: 32] = 32'h1000_0000 * (i + 1) + 32'(i);
    // R1 R2: identity, reverse, broadcast, mixed
    step("R2 imm identity",  1, s, 8'hE4, '0, 0, 1, 0, 4'hf);
    step("R2 imm reverse",   1, s, 8'h1B, '0, 0, 1, 0, 4'hf);
    step("R1 imm bcast 0",   1, s, 8'h00, '0, 0, 1, 0, 4'hf);
    step("R1 imm bcast 3",   1, s, 8'hFF, '0, 0, 1, 0, 4'hf);
    step("R2 imm mixed",     1, s, 8'h9C, '0, 0, 1, 0, 4'hf);
    // R3: low two bits select, upper control bits are noise
    c = rnd256();
    c_low = '0;
    for (int i = 0; i < 8; i++) c_low[i*32 +: 2] = c[i*32 +: 2];
    step("R3 var noisy ctl", 1, s, 8'h00, c, 1, 1, 0, 4'h3);
    step("R3 var clean ctl", 1, s, 8'h00, c_low, 1, 1, 0, 4'h3);
    // R4: narrow form
    step("R4 narrow imm",    1, s, 8'h1B, '0, 0, 0, 0, 4'hf);
    step("R4 narrow var",    1, s, 8'h00, c, 1, 0, 0, 4'h0);
    // R5 R7: bad specifier in immediate mode only
    step("R5 imm bad vvvv",  1, s, 8'hE4, '0, 0, 1, 0, 4'h7);
    step("R5 var any vvvv",  1, s, 8'h00, c, 1, 1, 0, 4'h0);
    // R6 R7: W set
    step("R6 imm W=1",       1, s, 8'hE4, '0, 0, 1, 1, 4'hf);
    step("R6 var W=1",       1, s, 8'h00, c, 1, 1, 1, 4'hf);
    // R10: the unused select source is ignored
    step("R10 imm ctl noise", 1, s, 8'h4E, rnd256(), 0, 1, 0, 4'hf);
    step("R10 var imm noise", 1, s, 8'($urandom), c_low, 1, 1, 0, 4'h5);
    // R8: holds across idle cycles
    for (int i = 0; i < 4; i++) idle("R8 hold idle");

    for (int i = 0; i < 300; i++) begin
      logic v = ($urandom % 4) != 0;
      step("R1 random", v, rnd256(), 8'($urandom), rnd256(), 1'($urandom),
           1'($urandom), ($urandom % 8) == 0, ($urandom % 3 == 0) ? 4'($urandom) : 4'hf);
    end

    // R9: asynchronous reset mid-run
    step("R9 pre-reset", 1, s, 8'h1B, '0, 0, 1, 0, 4'hf);
    rst_ni = 1'b0;
    #1;
    exp_valid = 0; exp_res = '0; exp_undef = 0;
    compare("R9 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step("R9 after reset", 1, s, 8'hE4, '0, 0, 1, 0, 4'hf);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule